// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is a single compare channel for a general-purpose timer. It watches a counter value and counting direction supplied from outside, compares the counter with a programmed compare value, and from the result and a 3-bit mode it builds an active-high reference waveform. It can freeze, set, clear or toggle the reference on a match, force it low or high, or run one of two PWM shapes that follow the counting direction.

Two output pins come from the reference: a true pin and a complementary pin. Each pin has its own polarity bit, applied after the reference. An external clear input can pull the reference low when clearing is enabled. A 2-bit direction field decides whether the channel is in compare use. Any non-zero value turns the channel into an input and drives both pins low.

Software reaches the channel through a small write port. The compare value can go through a shadow register that copies into the active register on a counter update event. A lock level of 3 protects the mode field from being changed.

Top module: `ocg_channel`

## Requirements
- R1: In mode 000 (freeze) the reference keeps its value, even when the counter equals the compare value.
- R2: In mode 001 the reference goes high, and in mode 010 it goes low, in the clock after the counter equals the active compare value. When there is no match, it holds.
- R3: In mode 011 the reference inverts in every clock in which the counter equals the active compare value, and holds otherwise.
- R4: Mode 100 drives the reference low and mode 101 drives it high, whatever the counter value.
- R5: Mode 110 (PWM A): when counting up (down=0), the reference is 1 while counter <= compare and 0 when counter > compare. When counting down, it is 1 only when counter > compare.
- R6: Mode 111 (PWM B) gives the inverse of mode 110 for the same counter, compare value and direction.
- R7: The true pin equals reference XOR pol_p. The complementary pin equals (NOT reference) XOR pol_n.
- R8: When clr_en=1, a high ext_clr_i drives the reference to 0 in the next clock. When clr_en=0, ext_clr_i has no effect.
- R9: When the direction field is not 00, both pins are 0. The reference continues to be computed.
- R10: While lock_lvl_i=3 and the stored direction field is 00, a control write leaves the mode field unchanged but still updates the other control fields.
- R11: When preload=1, a compare write goes to the shadow register and reaches the active register only on a clock with upd_evt_i=1. When preload=0, the write takes effect at once.
- R12: After reset, the mode is freeze, the reference is 0, both polarity bits are 0, the direction field is 00 and the compare value is 0. So the true pin is 0 and the complementary pin is 1.

The reference is registered: it reflects the inputs sampled at the previous rising clock edge. Control writes go to address 0, with this layout:
- bits [1:0]: direction field
- bit 2: preload enable
- bit 3: clr_en
- bits [6:4]: mode
- bit 7: pol_p
- bit 8: pol_n

Compare writes go to address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_i | input | CNT_W | Current counter value |
| cnt_down_i | input | 1 | 1 when the counter counts down |
| upd_evt_i | input | 1 | Counter update event (shadow copy strobe) |
| ext_clr_i | input | 1 | External clear request for the reference |
| lock_lvl_i | input | 2 | Lock level; 3 protects the mode field |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 compare |
| wr_data_i | input | CNT_W | Write data |
| ref_o | output | 1 | Active-high reference waveform |
| out_p_o | output | 1 | True output pin |
| out_n_o | output | 1 | Complementary output pin |

## Verification
A wrong mode register or a wrong active compare value shows up on ref_o and on both pins at the first clock edge where the counter crosses or equals the compare value. The PWM vectors place the counter just below, at and just above the compare value in both directions, so an off-by-one comparison is visible within one clock. A shadow register that leaks into the active register before an update event flips the PWM reference one clock after the write. A lock that fails to hold the mode changes the reference one clock after the blocked write.

// File: rtl/ocg_pkg.sv
package ocg_pkg;

  typedef enum logic [2:0] {
    OCM_FREEZE = 3'b000,
    OCM_SET    = 3'b001,
    OCM_CLR    = 3'b010,
    OCM_TOGGLE = 3'b011,
    OCM_LOW    = 3'b100,
    OCM_HIGH   = 3'b101,
    OCM_PWM_A  = 3'b110,
    OCM_PWM_B  = 3'b111
  } ocm_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMP  = 2'd1;

  localparam int CTL_DIR_LSB  = 0;
  localparam int CTL_PRELOAD  = 2;
  localparam int CTL_CLR_EN   = 3;
  localparam int CTL_MODE_LSB = 4;
  localparam int CTL_POL_P    = 7;
  localparam int CTL_POL_N    = 8;
  localparam int CTL_W        = 9;

  localparam logic [1:0] LOCK_MODE_LVL = 2'd3;
  localparam logic [1:0] DIR_COMPARE   = 2'b00;

  typedef struct packed {
    logic       pol_n;
    logic       pol_p;
    ocm_e       mode;
    logic       clr_en;
    logic       preload;
    logic [1:0] dir;
  } ocg_cfg_t;

endpackage

// File: rtl/ocg_cfg_regs.sv
module ocg_cfg_regs
  import ocg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       lock_lvl_i,
  input  logic             upd_evt_i,
  output ocg_cfg_t         cfg_o,
  output logic [CNT_W-1:0] cmp_act_o
);

  ocg_cfg_t         cfg_q, cfg_d;
  logic [CNT_W-1:0] shd_q, shd_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             ctl_wr, cmp_wr, mode_locked;
  logic             cfg_en, shd_en, act_en;

  assign ctl_wr      = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign cmp_wr      = wr_en_i && (wr_addr_i == ADDR_CMP);
  assign mode_locked = (lock_lvl_i == LOCK_MODE_LVL) && (cfg_q.dir == DIR_COMPARE);

  always_comb begin
    cfg_d         = cfg_q;
    cfg_d.dir     = wr_data_i[CTL_DIR_LSB +: 2];
    cfg_d.preload = wr_data_i[CTL_PRELOAD];
    cfg_d.clr_en  = wr_data_i[CTL_CLR_EN];
    cfg_d.pol_p   = wr_data_i[CTL_POL_P];
    cfg_d.pol_n   = wr_data_i[CTL_POL_N];
    if (!mode_locked) begin
      cfg_d.mode = ocm_e'(wr_data_i[CTL_MODE_LSB +: 3]);
    end
  end

  always_comb begin
    shd_d  = wr_data_i;
    shd_en = cmp_wr;
    act_d  = act_q;
    act_en = 1'b0;
    if (cmp_wr && !cfg_q.preload) begin
      act_d  = wr_data_i;
      act_en = 1'b1;
    end else if (upd_evt_i) begin
      act_d  = cmp_wr ? wr_data_i : shd_q;
      act_en = 1'b1;
    end
  end

  assign cfg_en = ctl_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{pol_n: 1'b0, pol_p: 1'b0, mode: OCM_FREEZE,
                 clr_en: 1'b0, preload: 1'b0, dir: DIR_COMPARE};
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
    end else if (shd_en) begin
      shd_q <= shd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  assign cfg_o     = cfg_q;
  assign cmp_act_o = act_q;

  AST_LOCK_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && lock_lvl_i == LOCK_MODE_LVL && cfg_q.dir == DIR_COMPARE) |=> $stable(cfg_q.mode)); // R10

  AST_PRELOAD_HOLDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && cfg_q.preload && !upd_evt_i) |=> $stable(act_q)); // R11

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && !cfg_q.preload) |=> (act_q == $past(wr_data_i))); // R11

endmodule

// File: rtl/ocg_ref_gen.sv
module ocg_ref_gen
  import ocg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ocm_e             mode_i,
  input  logic             clr_en_i,
  input  logic             ext_clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             ref_o
);

  logic ref_q, ref_d;
  logic hit, above, pwm_a, clr_req;

  assign hit     = (cnt_i == cmp_i);
  assign above   = (cnt_i > cmp_i);
  assign pwm_a   = cnt_down_i ? above : !above;
  assign clr_req = clr_en_i && ext_clr_i;

  always_comb begin
    ref_d = ref_q;
    unique case (mode_i)
      OCM_FREEZE: ref_d = ref_q;
      OCM_SET:    if (hit) ref_d = 1'b1;
      OCM_CLR:    if (hit) ref_d = 1'b0;
      OCM_TOGGLE: if (hit) ref_d = !ref_q;
      OCM_LOW:    ref_d = 1'b0;
      OCM_HIGH:   ref_d = 1'b1;
      OCM_PWM_A:  ref_d = pwm_a;
      OCM_PWM_B:  ref_d = !pwm_a;
      default:    ref_d = ref_q;
    endcase
    if (clr_req) begin
      ref_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
    end
  end

  assign ref_o = ref_q;

  AST_FREEZE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == OCM_FREEZE && !clr_req) |=> $stable(ref_q)); // R1

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == OCM_TOGGLE && hit && !clr_req) |=> (ref_q != $past(ref_q))); // R3

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == OCM_LOW) |=> !ref_q); // R4

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == OCM_HIGH && !clr_req) |=> ref_q); // R4

  AST_EXT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !ref_q); // R8

endmodule

// File: rtl/ocg_out_stage.sv
module ocg_out_stage #(
  parameter int NPIN = 2
) (
  input  logic            ref_i,
  input  logic            en_i,
  input  logic [NPIN-1:0] pol_i,
  output logic [NPIN-1:0] pin_o
);

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic base;
    if (g % 2 == 0) begin : g_true
      assign base = ref_i;
    end else begin : g_comp
      assign base = !ref_i;
    end
    assign pin_o[g] = en_i && (base ^ pol_i[g]);
  end

endmodule

// File: rtl/ocg_channel.sv
module ocg_channel
  import ocg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic             upd_evt_i,
  input  logic             ext_clr_i,
  input  logic [1:0]       lock_lvl_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             ref_o,
  output logic             out_p_o,
  output logic             out_n_o
);

  localparam int NPIN = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  ocg_cfg_t         cfg;
  logic [CNT_W-1:0] cmp_act;
  logic             ref_w;
  logic [NPIN-1:0]  pins;
  logic             out_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  ocg_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .lock_lvl_i (lock_lvl_i),
    .upd_evt_i  (upd_evt_i),
    .cfg_o      (cfg),
    .cmp_act_o  (cmp_act)
  );

  ocg_ref_gen #(.CNT_W(CNT_W)) u_ref (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .mode_i     (cfg.mode),
    .clr_en_i   (cfg.clr_en),
    .ext_clr_i  (ext_clr_i),
    .cnt_i      (cnt_i),
    .cnt_down_i (cnt_down_i),
    .cmp_i      (cmp_act),
    .ref_o      (ref_w)
  );

  assign out_en = (cfg.dir == DIR_COMPARE);

  ocg_out_stage #(.NPIN(NPIN)) u_out (
    .ref_i (ref_w),
    .en_i  (out_en),
    .pol_i ({cfg.pol_n, cfg.pol_p}),
    .pin_o (pins)
  );

  assign ref_o   = ref_w;
  assign out_p_o = pins[0];
  assign out_n_o = pins[1];

  AST_INPUT_DIR_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg.dir != DIR_COMPARE) |-> (!out_p_o && !out_n_o)); // R9

  AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg.dir == DIR_COMPARE) |-> ((out_p_o ^ out_n_o) == !(cfg.pol_p ^ cfg.pol_n))); // R7

endmodule

// File: tb/ocg_channel_bench.sv
`timescale 1ns/1ps
module ocg_channel_bench;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] cnt_i = '0;
  logic             cnt_down_i = 1'b0;
  logic             upd_evt_i = 1'b0;
  logic             ext_clr_i = 1'b0;
  logic [1:0]       lock_lvl_i = 2'd0;
  logic             wr_en_i = 1'b0;
  logic [1:0]       wr_addr_i = 2'd0;
  logic [CNT_W-1:0] wr_data_i = '0;
  logic             ref_o, out_p_o, out_n_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ocg_channel #(.CNT_W(CNT_W)) u_ocg_channel (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cnt_down_i(cnt_down_i),
    .upd_evt_i(upd_evt_i), .ext_clr_i(ext_clr_i), .lock_lvl_i(lock_lvl_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .ref_o(ref_o), .out_p_o(out_p_o), .out_n_o(out_n_o)
  );

  // vector: {mode[2:0], down, cnt[15:0], expected ref}; compare value 100
  localparam int NVEC = 14;
  localparam logic [20:0] VEC [0:NVEC-1] = '{
    {3'd6, 1'b0, 16'd50,  1'b1}, {3'd6, 1'b0, 16'd100, 1'b1},
    {3'd6, 1'b0, 16'd101, 1'b0}, {3'd6, 1'b1, 16'd50,  1'b0},
    {3'd6, 1'b1, 16'd101, 1'b1}, {3'd6, 1'b1, 16'd100, 1'b0},
    {3'd7, 1'b0, 16'd50,  1'b0}, {3'd7, 1'b0, 16'd100, 1'b0},
    {3'd7, 1'b0, 16'd101, 1'b1}, {3'd7, 1'b1, 16'd50,  1'b1},
    {3'd7, 1'b1, 16'd101, 1'b0}, {3'd7, 1'b1, 16'd100, 1'b1},
    {3'd4, 1'b0, 16'd100, 1'b0}, {3'd5, 1'b0, 16'd7,   1'b1}
  };

  function automatic logic [CNT_W-1:0] ctl(input logic [1:0] dir, input logic pre,
      input logic clr, input logic [2:0] mode, input logic pp, input logic pn);
    ctl = '0;
    ctl[8:0] = {pn, pp, mode, clr, pre, dir};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] addr, input logic [CNT_W-1:0] data);
    wr_en_i = 1'b1; wr_addr_i = addr; wr_data_i = data;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R12 reset state
    chk(ref_o, 1'b0, "R12 ref after reset");
    chk(out_p_o, 1'b0, "R12 true pin after reset");
    chk(out_n_o, 1'b1, "R12 comp pin after reset");
    wr(2'd0, ctl(2'b00, 0, 0, 3'd6, 0, 0));
    chk(ref_o, 1'b0, "R12 freeze mode held ref");
    cnt_i = 16'd0; tick();
    chk(ref_o, 1'b1, "R12 compare reset 0, cnt 0");
    cnt_i = 16'd1; tick();
    chk(ref_o, 1'b0, "R12 compare reset 0, cnt 1");

    // R5 R6 R4 vector table
    wr(2'd1, 16'd100);
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] m;
      m = VEC[i][20:18];
      wr(2'd0, ctl(2'b00, 0, 0, m, 0, 0));
      cnt_down_i = VEC[i][17];
      cnt_i      = VEC[i][16:1];
      tick();
      chk(ref_o, VEC[i][0], (m == 3'd6) ? "R5 PWM A vector" :
                            (m == 3'd7) ? "R6 PWM B vector" : "R4 forced vector");
    end
    cnt_down_i = 1'b0;

    // R2 set / clear on match
    wr(2'd1, 16'd20);
    wr(2'd0, ctl(2'b00, 0, 0, 3'd4, 0, 0));
    tick();
    wr(2'd0, ctl(2'b00, 0, 0, 3'd1, 0, 0));
    cnt_i = 16'd5; tick();
    chk(ref_o, 1'b0, "R2 set mode no match");
    cnt_i = 16'd20; tick();
    chk(ref_o, 1'b1, "R2 set on match");
    cnt_i = 16'd21; tick();
    chk(ref_o, 1'b1, "R2 set holds after match");
    wr(2'd0, ctl(2'b00, 0, 0, 3'd2, 0, 0));
    chk(ref_o, 1'b1, "R2 clear mode before match");
    cnt_i = 16'd20; tick();
    chk(ref_o, 1'b0, "R2 clear on match");

    // R3 toggle
    cnt_i = 16'd5;
    wr(2'd0, ctl(2'b00, 0, 0, 3'd3, 0, 0));
    chk(ref_o, 1'b0, "R3 toggle idle");
    cnt_i = 16'd20; tick();
    chk(ref_o, 1'b1, "R3 first toggle");
    tick();
    chk(ref_o, 1'b0, "R3 second toggle");
    cnt_i = 16'd5; tick();
    chk(ref_o, 1'b0, "R3 hold without match");

    // R1 freeze
    wr(2'd0, ctl(2'b00, 0, 0, 3'd5, 0, 0));
    tick();
    wr(2'd0, ctl(2'b00, 0, 0, 3'd0, 0, 0));
    cnt_i = 16'd20; tick();
    chk(ref_o, 1'b1, "R1 freeze ignores match");
    cnt_i = 16'd0; tick();
    chk(ref_o, 1'b1, "R1 freeze holds");

    // R7 polarity (ref = 1)
    wr(2'd0, ctl(2'b00, 0, 0, 3'd0, 1, 0));
    chk(out_p_o, 1'b0, "R7 true pin pol_p=1");
    chk(out_n_o, 1'b0, "R7 comp pin pol_n=0");
    wr(2'd0, ctl(2'b00, 0, 0, 3'd0, 0, 1));
    chk(out_p_o, 1'b1, "R7 true pin pol_p=0");
    chk(out_n_o, 1'b1, "R7 comp pin pol_n=1");
    wr(2'd0, ctl(2'b00, 0, 0, 3'd0, 0, 0));
    chk(out_p_o, 1'b1, "R7 true pin plain");
    chk(out_n_o, 1'b0, "R7 comp pin plain");

    // R8 external clear
    wr(2'd0, ctl(2'b00, 0, 1, 3'd5, 0, 0));
    ext_clr_i = 1'b1; tick();
    chk(ref_o, 1'b0, "R8 clear forces ref low");
    ext_clr_i = 1'b0; tick();
    chk(ref_o, 1'b1, "R8 release of clear");
    wr(2'd0, ctl(2'b00, 0, 0, 3'd5, 0, 0));
    ext_clr_i = 1'b1; tick();
    chk(ref_o, 1'b1, "R8 clear ignored when disabled");
    ext_clr_i = 1'b0;

    // R9 direction
    for (int d = 1; d < 4; d++) begin
      wr(2'd0, ctl(d[1:0], 0, 0, 3'd5, 0, 0));
      chk(out_p_o, 1'b0, "R9 true pin off in input use");
      chk(out_n_o, 1'b0, "R9 comp pin off in input use");
      chk(ref_o, 1'b1, "R9 ref still computed");
    end
    wr(2'd0, ctl(2'b00, 0, 0, 3'd5, 0, 0));
    chk(out_p_o, 1'b1, "R9 true pin back in compare use");

    // R10 lock
    lock_lvl_i = 2'd3;
    wr(2'd0, ctl(2'b00, 0, 0, 3'd4, 1, 0));
    tick();
    chk(ref_o, 1'b1, "R10 mode write blocked");
    chk(out_p_o, 1'b0, "R10 other field still written");
    lock_lvl_i = 2'd2;
    wr(2'd0, ctl(2'b00, 0, 0, 3'd4, 0, 0));
    tick();
    chk(ref_o, 1'b0, "R10 mode write at lower lock");
    lock_lvl_i = 2'd0;

    // R11 preload
    wr(2'd1, 16'd20);
    wr(2'd0, ctl(2'b00, 1, 0, 3'd6, 0, 0));
    wr(2'd1, 16'd50);
    cnt_i = 16'd30; tick();
    chk(ref_o, 1'b0, "R11 shadow not yet active");
    tick();
    chk(ref_o, 1'b0, "R11 shadow still held");
    upd_evt_i = 1'b1; tick();
    upd_evt_i = 1'b0; tick();
    chk(ref_o, 1'b1, "R11 shadow copied on update");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule